// File: doc/BRIEF.md
# Machine Check Capture and Response Unit

This block gathers error indications from the processor's data-path checkers and holds them in an eight-bit check register. Seven of the bits come from parity checkers that watch individual registers. The eighth bit comes from a duplicate ALU check: a second ALU result is computed from complemented operands, and a correct pair of results are bitwise complements of each other. The register is sticky. Every new error is ORed in, and the bits stay set until a check-reset is applied. The check-reset is accepted at any time, whether the processor clock is running or stopped. The latched bits drive a display.

The first cycle in which any bit becomes newly set triggers one reaction. The reaction is chosen by a five-position check-control mode:

- Ignore the error.
- Request a clock stop.
- Start a malfunction trap.
- Request a restart.
- Hand control to a diagnostic routine.

For a restart, a separate address-compare setting selects the kind of restart to perform. The trap handler, the restart sequencing and the parity generators sit outside this block.

Top module: `mchk_unit`

## Requirements
- R1: Each of the seven parity inputs sets the check bit of the same index on the next clock edge. The assignments are:
  - bit 0: A register
  - bit 1: B register
  - bit 2: storage address
  - bit 3: control register
  - bit 4: control-store sense latches
  - bit 5: control-store address
  - bit 6: storage data
- R2: When `alu_chk_en` is high and `alu_res` is not the bitwise complement of `alu_cmp_res`, check bit 7 is set on the next edge. When `alu_chk_en` is low, no ALU error is recorded.
- R3: Check bits are sticky. New errors are ORed in, and a set bit stays set while `chk_clr` is low.
- R4: With `chk_clr` high, the register becomes exactly the set of errors present in that same cycle. With no errors present, it becomes zero. This holds in every mode.
- R5: A reaction output is a one-cycle pulse, issued in the cycle after an edge that sets at least one bit that was clear. Errors that arrive only on bits already set produce no pulse.
- R6: In disable mode (`chk_mode` = 1), errors are logged, but no stop, trap, restart or diagnostic request is raised.
- R7: In stop mode (`chk_mode` = 2), a new error pulses `stop_req`.
- R8: In process mode (`chk_mode` = 0), and for the unused codes 5 to 7, a new error pulses `trap_req`.
- R9: In restart mode (`chk_mode` = 3), a new error pulses `restart_req`. The kind shown on `restart_kind` depends on `cmp_set`:
  - `cmp_set` = 7: kind 3 (full reset then instruction start).
  - `cmp_set` = 4 and 6: kind 1 (reset registers, then restart the control sequence). Only 6 also raises `restart_bypass`.
  - `cmp_set` = 5: kind 2 (restart the control sequence without reset).
  - Any other `cmp_set`: kind 0 (load the instruction counter and start).
  - `restart_kind` and `restart_bypass` are zero whenever `restart_req` is low.
- R10: In diagnostic mode (`chk_mode` = 4), a new error pulses `diag_req`.
- R11: During and right after reset, all check bits and all request outputs are zero.
- R12: At most one of the four request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_mode | input | 3 | Check-control mode: 0 process, 1 disable, 2 stop, 3 restart, 4 diagnostic |
| cmp_set | input | 3 | Address-compare setting, used to choose the restart kind |
| par_fail | input | 7 | Parity failure flags, one per watched register |
| alu_chk_en | input | 1 | ALU duplicate comparison is valid this cycle |
| alu_res | input | ALU_W | Normal ALU result |
| alu_cmp_res | input | ALU_W | ALU result computed from complemented operands |
| chk_clr | input | 1 | Check-reset: clears the latched check bits |
| chk_bits | output | 8 | Latched check register, for display |
| stop_req | output | 1 | Clock-stop request pulse |
| trap_req | output | 1 | Malfunction trap request pulse |
| restart_req | output | 1 | Restart request pulse |
| diag_req | output | 1 | Diagnostic routine request pulse |
| restart_kind | output | 2 | Restart kind, valid with restart_req |
| restart_bypass | output | 1 | Restart keeps main storage idle, valid with restart_req |

## Verification
The bound checker watches several behaviours on every cycle:
- Bits stay sticky without a clear.
- Every parity or ALU failure lands in its bit on the next edge.
- A clear with no errors empties the register.
- Requests are mutually exclusive, and none is raised in disable mode.
- The restart kind is zero whenever no restart is requested.

Other behaviours can only be shown by the bench's scenarios, through its reference model:
- A pulse fires exactly once, and only for newly set bits.
- Each mode maps to the correct reaction.
- Each address-compare setting maps to the correct restart kind.
- A clear arriving together with fresh errors keeps those errors.

// File: rtl/mchk_pkg.sv
package mchk_pkg;

    localparam int CHK_W      = 8;
    localparam int PAR_SRCS   = 7;
    localparam int ALU_BIT    = 7;

    typedef enum logic [2:0] {
        CM_PROCESS = 3'd0,
        CM_DISABLE = 3'd1,
        CM_STOP    = 3'd2,
        CM_RESTART = 3'd3,
        CM_DIAG    = 3'd4
    } chk_mode_e;

    typedef enum logic [2:0] {
        AC_NONE          = 3'd0,
        AC_SEQ_STOP      = 3'd1,
        AC_MEM_STOP      = 3'd2,
        AC_MEM_LATE_STOP = 3'd3,
        AC_SEQ_RESTART   = 3'd4,
        AC_SEQ_KEEP      = 3'd5,
        AC_SEQ_NOMEM     = 3'd6,
        AC_MEM_RESTART   = 3'd7
    } cmp_set_e;

    typedef enum logic [1:0] {
        RK_IC_START  = 2'd0,
        RK_SEQ_RESET = 2'd1,
        RK_SEQ_KEEP  = 2'd2,
        RK_FULL      = 2'd3
    } restart_kind_e;

    typedef struct packed {
        logic          stop;
        logic          trap;
        logic          restart;
        logic          diag;
        restart_kind_e kind;
        logic          bypass;
    } reaction_t;

    function automatic reaction_t choose_reaction(logic fire, chk_mode_e mode, cmp_set_e cs);
        reaction_t r;
        r = '0;
        if (fire) begin
            case (mode)
                CM_DISABLE: ;
                CM_STOP:    r.stop = 1'b1;
                CM_DIAG:    r.diag = 1'b1;
                CM_RESTART: begin
                    r.restart = 1'b1;
                    case (cs)
                        AC_MEM_RESTART: r.kind = RK_FULL;
                        AC_SEQ_RESTART: r.kind = RK_SEQ_RESET;
                        AC_SEQ_NOMEM: begin
                            r.kind   = RK_SEQ_RESET;
                            r.bypass = 1'b1;
                        end
                        AC_SEQ_KEEP:    r.kind = RK_SEQ_KEEP;
                        default:        r.kind = RK_IC_START;
                    endcase
                end
                default:    r.trap = 1'b1;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mchk_alu_cmp.sv
module mchk_alu_cmp #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] res,
    input  logic [W-1:0] cmp_res,
    output logic         mismatch
);
    logic [W-1:0] bit_ok;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign bit_ok[g] = res[g] ^ cmp_res[g];
    end

    assign mismatch = en && !(&bit_ok);
endmodule

// File: rtl/mchk_capture.sv
module mchk_capture #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [NBITS-1:0] flags,
    output logic [NBITS-1:0] bits,
    output logic             new_any
);
    logic [NBITS-1:0] bits_q;
    logic [NBITS-1:0] base;
    logic [NBITS-1:0] fresh;

    for (genvar g = 0; g < NBITS; g++) begin : g_latch
        assign base[g]  = clr ? 1'b0 : bits_q[g];
        assign fresh[g] = flags[g] & ~base[g];

        always_ff @(posedge clk) begin
            if (rst) bits_q[g] <= 1'b0;
            else     bits_q[g] <= base[g] | flags[g];
        end
    end

    assign bits    = bits_q;
    assign new_any = |fresh;
endmodule

// File: rtl/mchk_react.sv
module mchk_react
    import mchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  chk_mode_e mode,
    input  cmp_set_e  cs,
    output reaction_t act
);
    reaction_t act_q;

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= choose_reaction(fire, mode, cs);
    end

    assign act = act_q;
endmodule

// File: rtl/mchk_unit.sv
module mchk_unit
    import mchk_pkg::*;
#(
    parameter int ALU_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          chk_mode,
    input  logic [2:0]          cmp_set,
    input  logic [PAR_SRCS-1:0] par_fail,
    input  logic                alu_chk_en,
    input  logic [ALU_W-1:0]    alu_res,
    input  logic [ALU_W-1:0]    alu_cmp_res,
    input  logic                chk_clr,
    output logic [CHK_W-1:0]    chk_bits,
    output logic                stop_req,
    output logic                trap_req,
    output logic                restart_req,
    output logic                diag_req,
    output logic [1:0]          restart_kind,
    output logic                restart_bypass
);
    logic             alu_bad;
    logic [CHK_W-1:0] flags;
    logic             fire;
    reaction_t        act;

    mchk_alu_cmp #(.W(ALU_W)) i_alu_cmp (
        .en       (alu_chk_en),
        .res      (alu_res),
        .cmp_res  (alu_cmp_res),
        .mismatch (alu_bad)
    );

    always_comb begin
        flags                 = '0;
        flags[PAR_SRCS-1:0]   = par_fail;
        flags[ALU_BIT]        = alu_bad;
    end

    mchk_capture #(.NBITS(CHK_W)) i_capture (
        .clk     (clk),
        .rst     (rst),
        .clr     (chk_clr),
        .flags   (flags),
        .bits    (chk_bits),
        .new_any (fire)
    );

    mchk_react i_react (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .mode (chk_mode_e'(chk_mode)),
        .cs   (cmp_set_e'(cmp_set)),
        .act  (act)
    );

    assign stop_req       = act.stop;
    assign trap_req       = act.trap;
    assign restart_req    = act.restart;
    assign diag_req       = act.diag;
    assign restart_kind   = act.kind;
    assign restart_bypass = act.bypass;
endmodule

// File: rtl/mchk_checker.sv
module mchk_checker #(
    parameter int ALU_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       chk_mode,
    input logic [6:0]       par_fail,
    input logic             alu_chk_en,
    input logic [ALU_W-1:0] alu_res,
    input logic [ALU_W-1:0] alu_cmp_res,
    input logic             chk_clr,
    input logic [7:0]       chk_bits,
    input logic             stop_req,
    input logic             trap_req,
    input logic             restart_req,
    input logic             diag_req,
    input logic [1:0]       restart_kind,
    input logic             restart_bypass
);
    assert_par_capture_R1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((chk_bits[6:0] & $past(par_fail)) == $past(par_fail)));

    assert_alu_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && alu_chk_en && (alu_res != ~alu_cmp_res)) |=> chk_bits[7]);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && !chk_clr) |=> ((chk_bits & $past(chk_bits)) == $past(chk_bits)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && chk_clr && par_fail == '0 && !(alu_chk_en && (alu_res != ~alu_cmp_res)))
        |=> (chk_bits == '0));

    assert_req_has_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (stop_req || trap_req || restart_req || diag_req) |-> (chk_bits != '0));

    assert_disable_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && chk_mode == 3'd1) |=> !(stop_req || trap_req || restart_req || diag_req));

    assert_kind_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !restart_req |-> (restart_kind == 2'd0 && !restart_bypass));

    assert_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stop_req, trap_req, restart_req, diag_req}));
endmodule

bind mchk_unit mchk_checker #(.ALU_W(ALU_W)) i_mchk_checker (
    .clk            (clk),
    .rst            (rst),
    .chk_mode       (chk_mode),
    .par_fail       (par_fail),
    .alu_chk_en     (alu_chk_en),
    .alu_res        (alu_res),
    .alu_cmp_res    (alu_cmp_res),
    .chk_clr        (chk_clr),
    .chk_bits       (chk_bits),
    .stop_req       (stop_req),
    .trap_req       (trap_req),
    .restart_req    (restart_req),
    .diag_req       (diag_req),
    .restart_kind   (restart_kind),
    .restart_bypass (restart_bypass)
);

// File: tb/test_mchk_unit.sv
module test_mchk_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ALU_W      = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [2:0]       chk_mode;
    logic [2:0]       cmp_set;
    logic [6:0]       par_fail;
    logic             alu_chk_en;
    logic [ALU_W-1:0] alu_res;
    logic [ALU_W-1:0] alu_cmp_res;
    logic             chk_clr;
    logic [7:0]       chk_bits;
    logic             stop_req, trap_req, restart_req, diag_req;
    logic [1:0]       restart_kind;
    logic             restart_bypass;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    // reference model state
    logic [7:0] m_bits = '0;
    logic       m_stop = 0, m_trap = 0, m_rst_req = 0, m_diag = 0, m_byp = 0;
    logic [1:0] m_kind = '0;

    mchk_unit #(.ALU_W(ALU_W)) i_mchk_unit (
        .clk(clk), .rst(rst), .chk_mode(chk_mode), .cmp_set(cmp_set),
        .par_fail(par_fail), .alu_chk_en(alu_chk_en), .alu_res(alu_res),
        .alu_cmp_res(alu_cmp_res), .chk_clr(chk_clr), .chk_bits(chk_bits),
        .stop_req(stop_req), .trap_req(trap_req), .restart_req(restart_req),
        .diag_req(diag_req), .restart_kind(restart_kind),
        .restart_bypass(restart_bypass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0] inc, base, fresh;
        logic       fire;
        m_stop = 0; m_trap = 0; m_rst_req = 0; m_diag = 0; m_byp = 0; m_kind = 0;
        if (rst) begin
            m_bits = '0;
        end else begin
            inc   = {alu_chk_en && (alu_res != ~alu_cmp_res), par_fail};
            base  = chk_clr ? 8'h00 : m_bits;
            fresh = inc & ~base;
            m_bits = base | inc;
            fire  = (fresh != 0);
            if (fire) begin
                if (chk_mode == 3'd1) ;
                else if (chk_mode == 3'd2) m_stop = 1;
                else if (chk_mode == 3'd4) m_diag = 1;
                else if (chk_mode == 3'd3) begin
                    m_rst_req = 1;
                    if (cmp_set == 3'd7)                         m_kind = 2'd3;
                    else if (cmp_set == 3'd4 || cmp_set == 3'd6) m_kind = 2'd1;
                    else if (cmp_set == 3'd5)                    m_kind = 2'd2;
                    else                                         m_kind = 2'd0;
                    m_byp = (cmp_set == 3'd6);
                end else m_trap = 1;
            end
        end
    endtask

    task automatic step(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, "chk_bits", chk_bits, m_bits);
        check(tag, "stop_req", stop_req, m_stop);
        check(tag, "trap_req", trap_req, m_trap);
        check(tag, "restart_req", restart_req, m_rst_req);
        check(tag, "diag_req", diag_req, m_diag);
        check(tag, "restart_kind", restart_kind, m_kind);
        check(tag, "restart_bypass", restart_bypass, m_byp);
        check("R12", "request count", $countones({stop_req, trap_req, restart_req, diag_req}) <= 1, 1);
    endtask

    task automatic idle_inputs();
        par_fail = '0; alu_chk_en = 0; alu_res = 8'h5A; alu_cmp_res = 8'hA5; chk_clr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        rst = 1; chk_mode = 3'd1; cmp_set = 3'd0;
        idle_inputs();
        par_fail = 7'h7F;               // ignored under reset
        @(negedge clk);
        step("R11");
        step("R11");
        rst = 0; idle_inputs();
        step("R11");

        // R1: each parity source maps to its own bit (disable mode, R6)
        for (int k = 0; k < 7; k++) begin
            chk_clr = 1; step("R4");
            chk_clr = 0;
            par_fail = 7'(1 << k); step("R1");
            par_fail = '0;         step("R6");
        end

        // R3/R5: repeat on a set bit gives no pulse; new bit ORs in
        chk_clr = 1; step("R4"); chk_clr = 0;
        chk_mode = 3'd2;
        par_fail = 7'h01; step("R7");
        par_fail = 7'h01; step("R5");
        par_fail = 7'h08; step("R3");
        par_fail = '0;    step("R5");
        step("R3");

        // R4: clear in stop mode with no errors
        chk_clr = 1; step("R4"); chk_clr = 0; step("R4");

        // R2: ALU mismatch in process mode
        chk_mode = 3'd0;
        alu_chk_en = 1; alu_res = 8'h5A; alu_cmp_res = 8'hA5; step("R2");
        alu_cmp_res = 8'hA4; step("R2");
        alu_chk_en = 0; step("R8");
        chk_clr = 1; step("R4"); chk_clr = 0;
        alu_chk_en = 0; alu_cmp_res = 8'h00; step("R2");
        alu_cmp_res = 8'hA5;

        // R8: undefined mode codes trap
        for (int m = 5; m < 8; m++) begin
            chk_clr = 1; step("R4"); chk_clr = 0;
            chk_mode = 3'(m);
            par_fail = 7'h04; step("R8");
            par_fail = '0;    step("R8");
        end

        // R9: restart kinds, clear arriving with the error (R4)
        chk_mode = 3'd3;
        for (int c = 0; c < 8; c++) begin
            cmp_set = 3'(c);
            chk_clr = 1; par_fail = 7'(1 << (c % 7)); step("R9");
            chk_clr = 0; par_fail = '0; step("R9");
        end

        // R10: diagnostic mode with several sources together
        chk_mode = 3'd4; cmp_set = 3'd0;
        chk_clr = 1; step("R4"); chk_clr = 0;
        par_fail = 7'h70; step("R10");
        par_fail = '0; alu_chk_en = 1; alu_cmp_res = 8'h00; step("R10");
        alu_chk_en = 0; step("R10");

        // R6: disable mode with fresh bits including ALU
        chk_mode = 3'd1;
        chk_clr = 1; step("R4"); chk_clr = 0;
        par_fail = 7'h7F; alu_chk_en = 1; step("R6");
        idle_inputs(); step("R6");

        finish_run();
    end
endmodule